// File: doc/BRIEF.md
# Big-Endian Aligned Memory Access Sequencer

This block turns byte, word and longword requests from a core into bus cycles on a memory port with a 24-bit byte address space and a 16-bit data path. Each 16-bit row has an upper lane (bits 15:8) and a lower lane (bits 7:0), and each lane has its own active-high strobe. The even byte of a row sits on the upper lane, so data is stored most significant byte first. A longword becomes two word cycles, issued in ascending address order. Its two halves are assembled into one 32-bit result.

The request side is a valid/ready stream. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` stays low from the moment a request is taken until its response pulse has been shown, so only one request is in flight at a time. While `req_ready` is low, the request pins have no effect and a waiting request simply stays pending. The response carries no back-pressure: `rsp_valid` is a single-cycle pulse that the core must capture. On the memory side, each bus cycle is held until the memory raises `bus_ack`.

A word or longword request at an odd address moves no data. It produces a trap response and no bus activity.

Top module: `mem_seq`

## Requirements
- R1: `req_ready` is high exactly when no bus cycle is in progress and no response is being shown. A request is taken only on an edge where `req_valid` and `req_ready` are both high.
- R2: A request with size code 1 (word), 2 or 3 (longword) and address bit 0 set is misaligned. It produces no bus cycle. In the cycle after it is taken, `rsp_valid` and `rsp_trap` are both high for exactly one cycle.
- R3: A byte request (size code 0) makes one bus cycle at `bus_addr` = address bits 23:1.
  - At an even address, only `bus_uds` is raised and the byte travels on bits 15:8.
  - At an odd address, only `bus_lds` is raised and the byte travels on bits 7:0.
  - On a write, `req_wdata[7:0]` is driven on both lanes.
  - On a read, the byte from the selected lane is returned zero-extended in `rsp_rdata[7:0]`.
- R4: An aligned word request makes one bus cycle with both strobes raised.
  - On a write, `bus_wdata` is `req_wdata[15:0]`.
  - On a read, the row is returned zero-extended in `rsp_rdata[15:0]`.
- R5: An aligned longword request makes two bus cycles with both strobes raised.
  - The first cycle is at address A and carries `req_wdata[31:16]`.
  - The second cycle is at A+2 and carries `req_wdata[15:0]`.
  - A read returns {first row, second row}.
- R6: The A+2 address of a longword wraps modulo 2^24, so FFFFFE is followed by 000000.
- R7: During a bus cycle, `bus_addr`, `bus_uds`, `bus_lds`, `bus_we` and `bus_wdata` stay unchanged until the edge where `bus_ack` is high.
- R8: For an aligned request, `rsp_valid` is high for exactly one cycle, in the cycle after the edge that acknowledged its last bus cycle, with `rsp_trap` low.
- R9: After reset, no bus cycle or response is active and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 word, 2 or 3 longword |
| req_addr | input | 24 | Byte address |
| req_wdata | input | 32 | Write data, right-aligned for byte and word |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_trap | output | 1 | Completion was a misalignment trap |
| rsp_rdata | output | 32 | Read result, zero-extended |
| bus_cyc | output | 1 | Bus cycle in progress |
| bus_we | output | 1 | Bus cycle writes |
| bus_addr | output | 23 | Row address (byte address bits 23:1) |
| bus_uds | output | 1 | Upper lane (15:8) strobe |
| bus_lds | output | 1 | Lower lane (7:0) strobe |
| bus_wdata | output | 16 | Bus write data |
| bus_rdata | input | 16 | Bus read data, valid with bus_ack |
| bus_ack | input | 1 | Memory ready; ends the current bus cycle |

## Verification
The assertions assume that `bus_ack` is only raised while `bus_cyc` is high and that `bus_rdata` is valid on that edge. They also assume that the request pins change only between edges. The stimulus keeps to this: the bench memory acknowledges only a cycle it can see, with a delay of zero to three cycles. The bench drives requests on the falling edge and raises `req_valid` only after it has seen `req_ready` high. This keeps the one-in-flight rule intact.

// File: rtl/mem_seq_pkg.sv
package mem_seq_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2,
    SZ_LALT = 2'd3
  } size_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUS  = 2'd1,
    ST_RESP = 2'd2
  } state_e;
endpackage

// File: rtl/mem_seq_lane.sv
// Write-side lane steering: strobes and bus data for the current row.
module mem_seq_lane
  import mem_seq_pkg::*;
#(
  parameter int LANE_W = 8
) (
  input  size_e                   size,
  input  logic                    odd,
  input  logic                    second,
  input  logic [4*LANE_W-1:0]     wdata,
  output logic                    hi_stb,
  output logic                    lo_stb,
  output logic [2*LANE_W-1:0]     row_wdata
);
  localparam int ROW_W = 2 * LANE_W;

  always_comb begin
    unique case (size)
      SZ_BYTE: begin
        hi_stb    = !odd;
        lo_stb    = odd;
        row_wdata = {wdata[LANE_W-1:0], wdata[LANE_W-1:0]};
      end
      SZ_WORD: begin
        hi_stb    = 1'b1;
        lo_stb    = 1'b1;
        row_wdata = wdata[ROW_W-1:0];
      end
      default: begin
        hi_stb    = 1'b1;
        lo_stb    = 1'b1;
        row_wdata = second ? wdata[ROW_W-1:0] : wdata[2*ROW_W-1:ROW_W];
      end
    endcase
  end
endmodule

// File: rtl/mem_seq_pack.sv
// Read-side assembly: zero-extended byte/word, or two rows most significant first.
module mem_seq_pack
  import mem_seq_pkg::*;
#(
  parameter int LANE_W = 8
) (
  input  size_e                   size,
  input  logic                    odd,
  input  logic [2*LANE_W-1:0]     first_row,
  input  logic [2*LANE_W-1:0]     cur_row,
  output logic [4*LANE_W-1:0]     result
);
  localparam int ROW_W = 2 * LANE_W;

  always_comb begin
    unique case (size)
      SZ_BYTE: result = {{(3*LANE_W){1'b0}},
                         odd ? cur_row[LANE_W-1:0] : cur_row[ROW_W-1:LANE_W]};
      SZ_WORD: result = {{ROW_W{1'b0}}, cur_row};
      default: result = {first_row, cur_row};
    endcase
  end
endmodule

// File: rtl/mem_seq.sv
module mem_seq
  import mem_seq_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int LANE_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic                  req_write,
  input  logic [1:0]            req_size,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [4*LANE_W-1:0]   req_wdata,
  output logic                  rsp_valid,
  output logic                  rsp_trap,
  output logic [4*LANE_W-1:0]   rsp_rdata,
  output logic                  bus_cyc,
  output logic                  bus_we,
  output logic [ADDR_W-2:0]     bus_addr,
  output logic                  bus_uds,
  output logic                  bus_lds,
  output logic [2*LANE_W-1:0]   bus_wdata,
  input  logic [2*LANE_W-1:0]   bus_rdata,
  input  logic                  bus_ack
);
  localparam int ROW_W  = 2 * LANE_W;
  localparam int DATA_W = 4 * LANE_W;
  localparam int ROW_AW = ADDR_W - 1;

  state_e              state;
  size_e               sz_q;
  logic [ROW_AW-1:0]   row_q;
  logic                odd_q, we_q, second_q, trap_q;
  logic [DATA_W-1:0]   wd_q, rdata_q;
  logic [ROW_W-1:0]    first_q;

  logic                lane_hi, lane_lo;
  logic [ROW_W-1:0]    lane_wd;
  logic [DATA_W-1:0]   packed_rd;

  wire take     = req_valid && req_ready;
  wire misalign = (req_size != SZ_BYTE) && req_addr[0];
  wire is_long  = sz_q[1];

  mem_seq_lane #(.LANE_W(LANE_W)) u_lane (
    .size(sz_q), .odd(odd_q), .second(second_q), .wdata(wd_q),
    .hi_stb(lane_hi), .lo_stb(lane_lo), .row_wdata(lane_wd)
  );

  mem_seq_pack #(.LANE_W(LANE_W)) u_pack (
    .size(sz_q), .odd(odd_q), .first_row(first_q), .cur_row(bus_rdata),
    .result(packed_rd)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      sz_q     <= SZ_BYTE;
      row_q    <= '0;
      odd_q    <= 1'b0;
      we_q     <= 1'b0;
      second_q <= 1'b0;
      trap_q   <= 1'b0;
      wd_q     <= '0;
      rdata_q  <= '0;
      first_q  <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (take) begin
          sz_q     <= size_e'(req_size);
          row_q    <= req_addr[ADDR_W-1:1];
          odd_q    <= req_addr[0];
          we_q     <= req_write;
          wd_q     <= req_wdata;
          second_q <= 1'b0;
          trap_q   <= misalign;
          rdata_q  <= '0;
          state    <= misalign ? ST_RESP : ST_BUS;
        end
        ST_BUS: if (bus_ack) begin
          if (is_long && !second_q) begin
            second_q <= 1'b1;
            row_q    <= row_q + 1'b1;
            first_q  <= bus_rdata;
          end else begin
            rdata_q <= packed_rd;
            state   <= ST_RESP;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign req_ready = (state == ST_IDLE);
  assign bus_cyc   = (state == ST_BUS);
  assign bus_we    = bus_cyc && we_q;
  assign bus_uds   = bus_cyc && lane_hi;
  assign bus_lds   = bus_cyc && lane_lo;
  assign bus_addr  = row_q;
  assign bus_wdata = lane_wd;
  assign rsp_valid = (state == ST_RESP);
  assign rsp_trap  = rsp_valid && trap_q;
  assign rsp_rdata = rdata_q;

  p_ready_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !bus_cyc && !rsp_valid);

  p_trap_no_bus_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_trap |-> rsp_valid && !$past(bus_cyc));

  p_strobe_live_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_cyc |-> (bus_uds || bus_lds));

  p_quiet_bus_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_cyc |-> !bus_uds && !bus_lds && !bus_we);

  p_next_row_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_cyc && bus_ack && is_long && !second_q |=>
      bus_cyc && (bus_addr == $past(bus_addr) + 1'b1));

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_cyc && !bus_ack |=> bus_cyc && $stable(bus_addr) && $stable(bus_uds)
      && $stable(bus_lds) && $stable(bus_we) && $stable(bus_wdata));

  p_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
endmodule

// File: tb/sim_mem_seq.sv
`timescale 1ns/1ps
module sim_mem_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [1:0]  req_size = 2'd0;
  logic [23:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        req_ready, rsp_valid, rsp_trap;
  logic [31:0] rsp_rdata;
  logic        bus_cyc, bus_we, bus_uds, bus_lds;
  logic [22:0] bus_addr;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata = '0;
  logic        bus_ack = 1'b0;

  int checks = 0;
  int errors = 0;
  bit running = 1'b0;

  always #2.5 clk = ~clk;

  mem_seq u0 (.*);

  typedef struct {
    bit [22:0] a;
    bit u, l, we, last;
    bit [15:0] d;
    string tag;
  } cyc_t;
  typedef struct {
    bit trap, rd;
    bit [31:0] d;
    string tag;
  } rsp_t;

  cyc_t exp_cyc[$];
  rsp_t exp_rsp[$];
  bit [7:0] mem [int];
  int dly = 0;
  int nack = 0;

  function automatic bit [7:0] rdb(bit [23:0] a);
    if (mem.exists(int'(a))) return mem[int'(a)];
    return a[7:0] ^ a[15:8] ^ 8'h5a;
  endfunction

  task automatic check(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic push_cyc(bit [23:0] ba, bit u, bit l, bit we, bit [15:0] d, bit last, string tag);
    cyc_t c;
    c.a = ba[23:1]; c.u = u; c.l = l; c.we = we; c.d = d; c.last = last; c.tag = tag;
    exp_cyc.push_back(c);
  endtask

  // Per-clock reference comparison and memory responder
  always @(negedge clk) if (running) begin
    if (bus_ack) begin
      cyc_t c;
      c = exp_cyc.pop_front();
      bus_ack = 1'b0;
      nack++;
      dly = (nack * 3) % 4;
      if (c.last) check(rsp_valid == 1'b1, "R8", "response one cycle after last ack", 32'(rsp_valid), 1);
    end
    if (rsp_valid) begin
      if (exp_rsp.size() == 0) check(1'b0, "R8", "unexpected response", 1, 0);
      else begin
        rsp_t r;
        r = exp_rsp.pop_front();
        check(rsp_trap == r.trap, r.tag, "trap flag", 32'(rsp_trap), 32'(r.trap));
        if (r.rd && !r.trap) check(rsp_rdata == r.d, r.tag, "read data", rsp_rdata, r.d);
      end
    end
    check(req_ready == (!bus_cyc && !rsp_valid), "R1", "ready", 32'(req_ready), 32'(!bus_cyc && !rsp_valid));
    if (bus_cyc) begin
      if (exp_cyc.size() == 0) check(1'b0, "R2", "unexpected bus cycle", 32'(bus_addr), 0);
      else begin
        cyc_t c;
        c = exp_cyc[0];
        check(bus_addr == c.a, c.tag, "bus_addr", 32'(bus_addr), 32'(c.a));
        check({bus_uds, bus_lds} == {c.u, c.l}, c.tag, "strobes", 32'({bus_uds, bus_lds}), 32'({c.u, c.l}));
        check(bus_we == c.we, c.tag, "bus_we", 32'(bus_we), 32'(c.we));
        if (c.we) check(bus_wdata == c.d, c.tag, "bus_wdata (R7 hold)", 32'(bus_wdata), 32'(c.d));
      end
      if (dly == 0) begin
        bit [23:0] e;
        e = {bus_addr, 1'b0};
        if (bus_we && bus_uds) mem[int'(e)] = bus_wdata[15:8];
        if (bus_we && bus_lds) mem[int'(e | 24'd1)] = bus_wdata[7:0];
        bus_rdata = {rdb(e), rdb(e | 24'd1)};
        bus_ack = 1'b1;
      end else dly--;
    end else begin
      check(!bus_uds && !bus_lds, "R3", "strobes idle", 32'({bus_uds, bus_lds}), 0);
    end
  end

  task automatic issue(bit we, bit [1:0] sz, bit [23:0] a, bit [31:0] wd, string tag);
    rsp_t r;
    bit mis;
    bit [23:0] a2;
    mis = (sz != 2'd0) && a[0];
    a2 = a + 24'd2;
    r.trap = mis; r.rd = !we; r.tag = tag; r.d = '0;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    if (!mis) begin
      if (sz == 2'd0) begin
        push_cyc(a, !a[0], a[0], we, {wd[7:0], wd[7:0]}, 1'b1, tag);
        r.d = {24'd0, rdb(a)};
      end else if (sz == 2'd1) begin
        push_cyc(a, 1'b1, 1'b1, we, wd[15:0], 1'b1, tag);
        r.d = {16'd0, rdb(a), rdb(a + 24'd1)};
      end else begin
        push_cyc(a, 1'b1, 1'b1, we, wd[31:16], 1'b0, tag);
        push_cyc(a2, 1'b1, 1'b1, we, wd[15:0], 1'b1, tag);
        r.d = {rdb(a), rdb(a + 24'd1), rdb(a2), rdb(a2 + 24'd1)};
      end
    end
    exp_rsp.push_back(r);
    req_valid = 1'b1; req_write = we; req_size = sz; req_addr = a; req_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    req_wdata = 32'hdead_beef;
    if (mis) check(rsp_valid && rsp_trap, "R2", "trap in cycle after accept", 32'({rsp_valid, rsp_trap}), 3);
    while (exp_rsp.size() != 0) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(req_ready == 1'b1, "R9", "ready after reset", 32'(req_ready), 1);
    check(bus_cyc == 1'b0, "R9", "no bus cycle after reset", 32'(bus_cyc), 0);
    check(rsp_valid == 1'b0, "R9", "no response after reset", 32'(rsp_valid), 0);
    rst_n = 1'b1;
    running = 1'b1;

    issue(1, 2'd0, 24'h000100, 32'h0000_00a5, "R3");
    issue(1, 2'd0, 24'h000101, 32'h0000_003c, "R3");
    issue(0, 2'd1, 24'h000100, 0, "R4");
    issue(0, 2'd0, 24'h000101, 0, "R3");
    issue(0, 2'd0, 24'h000100, 0, "R3");
    issue(1, 2'd1, 24'h000200, 32'hffff_1234, "R4");
    issue(0, 2'd1, 24'h000200, 0, "R4");
    issue(1, 2'd2, 24'h000300, 32'hcafe_f00d, "R5");
    issue(0, 2'd2, 24'h000300, 0, "R5");
    issue(0, 2'd1, 24'h000302, 0, "R5");
    issue(1, 2'd3, 24'h000400, 32'h0102_0304, "R5");
    issue(0, 2'd0, 24'h000403, 0, "R5");
    issue(1, 2'd1, 24'h000201, 32'h0000_9999, "R2");
    issue(1, 2'd2, 24'h000301, 32'h7777_7777, "R2");
    issue(0, 2'd3, 24'h000303, 0, "R2");
    issue(0, 2'd2, 24'h000300, 0, "R2");
    issue(0, 2'd1, 24'h000200, 0, "R2");
    issue(1, 2'd2, 24'hfffffe, 32'h89ab_cdef, "R6");
    issue(0, 2'd2, 24'hfffffe, 0, "R6");
    issue(0, 2'd1, 24'h000000, 0, "R6");
    issue(0, 2'd0, 24'hffffff, 0, "R3");
    for (int i = 0; i < 12; i++)
      issue(i % 2 == 0, 2'(i % 4), 24'h001000 + 24'(i * 6), 32'h1111_0000 + 32'(i * 13), "R7");

    repeat (4) @(negedge clk);
    check(exp_cyc.size() == 0, "R5", "bus cycles outstanding", 32'(exp_cyc.size()), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R1 watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule